// File: doc/BRIEF.md
# Clickless Gain Ramp

This block scales a stream of signed 24-bit audio samples by a 14-bit linear gain, so that a new gain is reached gradually and large level changes do not produce an audible click. The gain word is a plain multiplier: it is not a decibel code.

The block holds two gain values:

- **Target gain.** A control agent writes this value with a load pulse.
- **Live gain.** This is the value actually applied to the samples.

The live gain is split into two fields that behave differently:

- **Coarse field (upper 10 bits).** On every sample strobe it moves one count toward the target's coarse field. It never steps past 0 or 1023.
- **Fine field (lower 4 bits).** It follows the target's fine field as soon as a request is loaded, with no ramp.

Because only the coarse field ramps, a swing across the full range takes at most 1023 sample strobes.

Each strobed sample is multiplied by the live gain as it stood before that strobe's step. The product is divided by 2^14 with truncation toward zero and appears one clock later, together with an output valid.

Top module: `gain_ramp_top`

## Requirements
- R1: The output sample equals trunc(x * G / 16384), truncated toward zero. Here x is the signed input sample and G is the unsigned 14-bit live gain in the cycle of the strobe.
- R2: On each sample strobe, the coarse field (live gain bits 13:4) moves by exactly one count toward the target's bits 13:4.
- R3: From the cycle after a load pulse, live gain bits 3:0 equal the loaded request's bits 3:0.
- R4: The coarse field holds when it equals the target's coarse field, and it never changes in a cycle without a sample strobe.
- R5: A new request loaded during a ramp redirects the ramp toward the new target, including a reversal of direction.
- R6: From a live gain of 0, after a request of 16383 the coarse field reaches 1023 after exactly 1023 strobes.
- R7: The output valid is high exactly in the cycle after a sample strobe.
- R8: After reset, the target and live gain are 0, the output valid is low and the output sample is 0. A sample then produces output 0.
- R9: When a load and a strobe occur in the same cycle, that strobe's step heads toward the previous target, and its output uses the previous gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gain_req | input | 14 | Requested linear gain |
| gain_load | input | 1 | One-cycle pulse that captures `gain_req` |
| smp_vld | input | 1 | Input sample strobe |
| smp_in | input | 24 | Signed input sample |
| out_vld | output | 1 | Output sample valid |
| out_smp | output | 24 | Signed scaled output sample |

## Verification
The in-RTL assertions check on every cycle that:

- the coarse field moves by at most one count per strobe, and never without a strobe;
- the coarse field holds once it matches the target;
- the fine field tracks each load;
- the output valid follows the strobe by one cycle;
- a zero gain gives silence.

The remaining behaviour can only be shown by the bench's scenarios, with every output compared against an arithmetic model:

- the exact rounding of the product across many sample and gain pairs;
- the full 1023-strobe ramp length;
- a redirection that reverses direction;
- the ordering when a load and a strobe coincide.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  localparam int GAIN_W_DEF   = 14;
  localparam int FINE_W_DEF   = 4;
  localparam int SAMPLE_W_DEF = 24;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } ramp_dir_e;
endpackage

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
  import gain_ramp_pkg::*;
#(
  parameter int GAIN_W = GAIN_W_DEF,
  parameter int FINE_W = FINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] gain_req,
  input  logic              gain_load,
  input  logic              smp_vld,
  output logic [GAIN_W-1:0] live_gain
);
  localparam int COARSE_W = GAIN_W - FINE_W;

  logic [GAIN_W-1:0]   tgt_q, tgt_d;
  logic [COARSE_W-1:0] crs_q, crs_d;
  logic [COARSE_W-1:0] tgt_crs;
  ramp_dir_e           dir;

  assign tgt_crs = tgt_q[GAIN_W-1:FINE_W];

  always_comb begin
    if (crs_q < tgt_crs)      dir = DIR_UP;
    else if (crs_q > tgt_crs) dir = DIR_DOWN;
    else                      dir = DIR_HOLD;
  end

  always_comb begin
    tgt_d = tgt_q;
    crs_d = crs_q;
    if (smp_vld) begin
      case (dir)
        DIR_UP:   crs_d = crs_q + 1'b1;
        DIR_DOWN: crs_d = crs_q - 1'b1;
        default:  crs_d = crs_q;
      endcase
    end
    if (gain_load) tgt_d = gain_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      crs_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      crs_q <= crs_d;
    end
  end

  assign live_gain = {crs_q, tgt_q[FINE_W-1:0]};

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (crs_q != tgt_crs) |=>
      ((crs_q == $past(crs_q) + 1'b1) || (crs_q == $past(crs_q) - 1'b1)));
  p_hold_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_q == tgt_crs) |=> $stable(crs_q));
  p_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(crs_q));
  p_fine_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gain_load |=> (live_gain[FINE_W-1:0] == $past(gain_req[FINE_W-1:0])));
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
  import gain_ramp_pkg::*;
#(
  parameter int GAIN_W   = GAIN_W_DEF,
  parameter int SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic [GAIN_W-1:0]   gain,
  output logic                out_vld,
  output logic [SAMPLE_W-1:0] out_smp
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   biased;
  logic signed [PROD_W-1:0]   shifted;
  logic        [SAMPLE_W-1:0] smp_d;

  always_comb begin
    prod    = PROD_W'($signed(smp_in)) * $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
    biased  = prod[PROD_W-1] ? prod + PROD_W'((1 << GAIN_W) - 1) : prod;
    shifted = biased >>> GAIN_W;
    smp_d   = shifted[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_smp <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) out_smp <= smp_d;
    end
  end

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !out_vld);
  p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (gain == '0) |=> (out_smp == '0));
endmodule

// File: rtl/gain_ramp_top.sv
module gain_ramp_top
  import gain_ramp_pkg::*;
#(
  parameter int GAIN_W   = GAIN_W_DEF,
  parameter int FINE_W   = FINE_W_DEF,
  parameter int SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GAIN_W-1:0]   gain_req,
  input  logic                gain_load,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_in,
  output logic                out_vld,
  output logic [SAMPLE_W-1:0] out_smp
);
  logic [GAIN_W-1:0] live_gain;

  gain_ramp_ctrl #(.GAIN_W(GAIN_W), .FINE_W(FINE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gain_req  (gain_req),
    .gain_load (gain_load),
    .smp_vld   (smp_vld),
    .live_gain (live_gain)
  );

  gain_scaler #(.GAIN_W(GAIN_W), .SAMPLE_W(SAMPLE_W)) u_scale (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .smp_in  (smp_in),
    .gain    (live_gain),
    .out_vld (out_vld),
    .out_smp (out_smp)
  );
endmodule

// File: tb/gain_ramp_top_tb.sv
module gain_ramp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] gain_req = '0;
  logic        gain_load = 1'b0;
  logic        smp_vld = 1'b0;
  logic [23:0] smp_in = '0;
  logic        out_vld;
  logic [23:0] out_smp;

  int n_chk = 0;
  int n_bad = 0;
  int m_crs = 0;
  int m_req = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  gain_ramp_top u_dut (
    .clk(clk), .rst_n(rst_n), .gain_req(gain_req), .gain_load(gain_load),
    .smp_vld(smp_vld), .smp_in(smp_in), .out_vld(out_vld), .out_smp(out_smp)
  );

  function automatic int live();
    return m_crs * 16 + (m_req % 16);
  endfunction

  function automatic void step_model();
    int tc = m_req / 16;
    if (m_crs < tc) m_crs++;
    else if (m_crs > tc) m_crs--;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int g);
    @(negedge clk);
    gain_req = 14'(g); gain_load = 1'b1;
    @(negedge clk);
    gain_load = 1'b0;
    m_req = g;
  endtask

  // One strobe; output checked against the model (R1, R7); model then steps (R2).
  task automatic strobe(input int s, input bit with_load, input int g, input string req);
    longint exp;
    @(negedge clk);
    smp_in = 24'(s); smp_vld = 1'b1;
    if (with_load) begin gain_req = 14'(g); gain_load = 1'b1; end
    exp = (longint'(s) * longint'(live())) / 16384;
    step_model();
    if (with_load) m_req = g;
    @(negedge clk);
    smp_vld = 1'b0; gain_load = 1'b0;
    check({req, " value"}, longint'($signed(out_smp)), exp);
    check("R7 valid", longint'(out_vld), 1);
  endtask

  function automatic int next_pat(input int k);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    case (k % 6)
      0: return 8388607;
      1: return -8388608;
      2: return 1;
      3: return -1;
      4: return -777777;
      default: return int'($signed(lfsr[23:0]));
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state and silence
    check("R8 valid", longint'(out_vld), 0);
    check("R8 out", longint'($signed(out_smp)), 0);
    strobe(8388607, 0, 0, "R8");
    @(negedge clk);
    check("R7 valid low after strobe", longint'(out_vld), 0);

    // R3 fine follows at once, R6 full ramp
    load(16383);
    strobe(-8388608, 0, 0, "R3");
    check("R3 fine only", longint'($signed(out_smp)), -15 * 512);
    for (int k = 0; k < 1021; k++) strobe(next_pat(k), 0, 0, "R1 R2 up");
    strobe(-8388608, 0, 0, "R6 pre");
    check("R6 one short", longint'($signed(out_smp)), -16367 * 512);
    strobe(-8388608, 0, 0, "R6");
    check("R6 reached", longint'($signed(out_smp)), -16383 * 512);

    // R4 hold with and without strobes
    for (int k = 0; k < 3; k++) strobe(-8388608, 0, 0, "R4 hold");
    repeat (5) @(negedge clk);
    strobe(-8388608, 0, 0, "R4 idle");
    check("R4 still full", longint'($signed(out_smp)), -16383 * 512);

    // R5 redirect with reversal
    load(500 * 16 + 9);
    for (int k = 0; k < 10; k++) strobe(next_pat(k), 0, 0, "R5 down");
    load(1020 * 16 + 2);
    for (int k = 0; k < 5; k++) strobe(next_pat(k + 3), 0, 0, "R5 up");
    strobe(-8388608, 0, 0, "R5");
    check("R5 reversed", longint'($signed(out_smp)), -(1018 * 16 + 2) * 512);

    // R9 load and strobe in the same cycle
    strobe(-8388608, 1, 5, "R9");
    check("R9 old gain", longint'($signed(out_smp)), -(1019 * 16 + 2) * 512);
    strobe(-8388608, 0, 0, "R9 after");
    check("R9 stepped up", longint'($signed(out_smp)), -(1020 * 16 + 5) * 512);

    // R1 R2 full downward sweep to coarse 0, fine 5
    for (int k = 0; k < 1030; k++) strobe(next_pat(k), 0, 0, "R1 R2 down");
    strobe(-8388608, 0, 0, "R4 bottom");
    check("R4 bottom", longint'($signed(out_smp)), -5 * 512);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule